// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit drives the memory side of a multi-register block transfer. A single start request supplies a base address, a 16-bit register mask, an index-before/after flag, a direction flag and a load/store flag. The sequencer then issues one memory beat per accepted cycle. Each beat carries a word address, the number of the register being moved and a write enable.

Addresses in a transfer always climb by 4 bytes, and register numbers always climb with them. The lowest-numbered register in the mask therefore sits at the lowest address in every mode. The direction flag only picks whether the block lies above or below the base. The index flag only picks whether the base word itself is included in the block.

When the final beat is accepted, the sequencer raises a one-cycle completion pulse. It also presents the updated base, which is the base moved by four bytes per register in the chosen direction. An empty mask completes at once with no beats. Start requests that arrive while a transfer is running are ignored.

Top module: `lsm_addr_seq`

## Requirements
- R1: With pre_i=0 and up_i=1, beat k (k from 0) uses address base+4k.
- R2: With pre_i=1 and up_i=1, beat k uses address base+4+4k.
- R3: With pre_i=0 and up_i=0, for n selected registers beat k uses address base-4(n-1)+4k, so the last beat is at base.
- R4: With pre_i=1 and up_i=0, beat k uses address base-4n+4k, so the last beat is at base-4.
- R5: The number of beats equals the count of set bits in reg_list_i. Beats present the set register numbers in ascending order on reg_idx_o, and each address is 4 above the previous one.
- R6: mem_we_o is 1 on every beat of a transfer started with load_i=0, and 0 on every beat of a transfer started with load_i=1.
- R7: A beat completes only in a cycle where mem_req_o and mem_ready_i are both 1. While mem_ready_i is 0, the address and the register number are held.
- R8: done_o is high for exactly one cycle, in the cycle after the last beat completes, with mem_req_o low. From then on, wb_base_o equals base+4n when up_i=1 and base-4n when up_i=0.
- R9: If start_i is sampled with an empty mask, done_o is high in the next cycle, no beat is issued, and wb_base_o equals the base.
- R10: start_i is sampled only while busy_o is 0. A start during a transfer does not change that transfer's beats or its wb_base_o.
- R11: After reset, mem_req_o, done_o and busy_o are 0 and wb_base_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| base_i | input | AW | Base address |
| reg_list_i | input | NREG | Register mask, bit i selects register i |
| pre_i | input | 1 | 1: step before access, 0: access before step |
| up_i | input | 1 | 1: block above base, 0: block below base |
| load_i | input | 1 | 1: memory to registers, 0: registers to memory |
| mem_ready_i | input | 1 | Memory accepts the current beat |
| mem_req_o | output | 1 | Beat valid |
| mem_addr_o | output | AW | Beat address |
| mem_we_o | output | 1 | Beat is a write |
| reg_idx_o | output | $clog2(NREG) | Register number for the beat |
| busy_o | output | 1 | Transfer in progress, including the completion cycle |
| done_o | output | 1 | One-cycle completion pulse |
| wb_base_o | output | AW | Updated base value |

## Verification
Some properties are checked on every cycle by the in-line assertions. Between consecutive beats, the address rises by exactly 4 and the register number strictly increases. A stalled beat holds its address and register number. The write enable stays constant within a transfer. done_o never lasts two cycles. A start during a transfer leaves the latched updated base unchanged.

Other behaviour can only be shown by the bench's scenarios. These cover the absolute placement of the block for each of the four index/direction modes, including address wrap-around, and the exact beat count. They also cover the updated base value, completion for an empty mask, and the fact that an ignored start leaves the running beat sequence intact.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int unsigned STEP_BYTES = 4;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int N  = 16,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // scan downward so the lowest set bit wins
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan
  import lsm_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          pre_i,
  input  logic          up_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] wb_o
);
  localparam logic [AW-1:0] STEP = AW'(STEP_BYTES);
  logic [AW-1:0] span;

  always_comb begin
    span = AW'(cnt_i) * STEP;
    if (up_i) begin
      wb_o    = base_i + span;
      first_o = pre_i ? base_i + STEP : base_i;
    end else begin
      wb_o    = base_i - span;
      // lowest register at lowest address: block starts at the bottom
      first_o = pre_i ? wb_o : wb_o + STEP;
    end
  end
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] reg_list_i,
  input  logic            pre_i,
  input  logic            up_i,
  input  logic            load_i,
  input  logic            mem_ready_i,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_we_o,
  output logic [IW-1:0]   reg_idx_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [AW-1:0]   wb_base_o
);
  localparam logic [AW-1:0] STEP = AW'(STEP_BYTES);

  seq_state_e      state_q;
  logic [NREG-1:0] pend_q, pend_nxt;
  logic [AW-1:0]   addr_q, wb_q, first_addr, wb_calc;
  logic            we_q;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   cur_idx;
  logic            cur_any;

  lsm_popcnt #(.N(NREG)) u_cnt (.vec_i(reg_list_i), .cnt_o(cnt));

  lsm_addr_plan #(.AW(AW), .CW(CW)) u_plan (
    .base_i (base_i),
    .cnt_i  (cnt),
    .pre_i  (pre_i),
    .up_i   (up_i),
    .first_o(first_addr),
    .wb_o   (wb_calc)
  );

  lsm_lowbit #(.N(NREG)) u_low (.vec_i(pend_q), .idx_o(cur_idx), .any_o(cur_any));

  always_comb begin
    pend_nxt = pend_q;
    if (cur_any) pend_nxt[cur_idx] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wb_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pend_q  <= reg_list_i;
          addr_q  <= first_addr;
          we_q    <= ~load_i;
          wb_q    <= wb_calc;
          state_q <= (reg_list_i == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: if (mem_ready_i) begin
          pend_q <= pend_nxt;
          addr_q <= addr_q + STEP;
          if (pend_nxt == '0) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_RUN);
  assign mem_addr_o = addr_q;
  assign mem_we_o   = mem_req_o & we_q;
  assign reg_idx_o  = cur_idx;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign wb_base_o  = wb_q;

  AST_ADDR_CLIMB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + STEP)); // R5
  AST_IDX_CLIMB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i) |=> (!mem_req_o || reg_idx_o > $past(reg_idx_o))); // R5
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(reg_idx_o))); // R7
  AST_WE_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i) |=> (!mem_req_o || $stable(mem_we_o))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(wb_base_o)); // R10
endmodule

// File: tb/lsm_addr_seq_test.sv
module lsm_addr_seq_test;
  localparam int AW = 32;
  localparam int NREG = 16;
  localparam int IW = $clog2(NREG);

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] list;
    logic        pre;
    logic        up;
    logic        load;
    logic [31:0] first;
    logic [31:0] wb;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 16'h0007, 1'b0, 1'b1, 1'b1, 32'h0000_1000, 32'h0000_100C},
    '{32'h0000_1000, 16'h8001, 1'b1, 1'b1, 1'b0, 32'h0000_1004, 32'h0000_1008},
    '{32'h0000_2000, 16'h00F0, 1'b0, 1'b0, 1'b1, 32'h0000_1FF4, 32'h0000_1FF0},
    '{32'h0000_2000, 16'h0501, 1'b1, 1'b0, 1'b0, 32'h0000_1FF4, 32'h0000_1FF4},
    '{32'h0000_0010, 16'hFFFF, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFD0, 32'hFFFF_FFD0},
    '{32'hFFFF_FFF0, 16'h0003, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFF4, 32'hFFFF_FFF8}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [AW-1:0]   base = '0;
  logic [NREG-1:0] list = '0;
  logic            pre = 1'b0, up = 1'b0, load = 1'b0, ready = 1'b1;
  logic            req, we, busy, done;
  logic [AW-1:0]   addr, wb;
  logic [IW-1:0]   idx;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  lsm_addr_seq #(.AW(AW), .NREG(NREG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
    .reg_list_i(list), .pre_i(pre), .up_i(up), .load_i(load),
    .mem_ready_i(ready), .mem_req_o(req), .mem_addr_o(addr),
    .mem_we_o(we), .reg_idx_o(idx), .busy_o(busy), .done_o(done),
    .wb_base_o(wb)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int low_set(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) if (v[i]) low_set = i;
  endfunction

  task automatic kick(input vec_t v);
    @(negedge clk);
    base = v.base; list = v.list; pre = v.pre; up = v.up; load = v.load;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // runs beats with ready high, checks each and the completion
  task automatic run_checks(input vec_t v, input string mtag);
    logic [15:0] rem;
    int n;
    rem = v.list;
    n = 0;
    while (rem != 16'h0 && n < 20) begin
      chk(req == 1'b1, "R5 req", 32'(req), 32'd1);
      chk(addr == v.first + 32'(4 * n), mtag, addr, v.first + 32'(4 * n));
      chk(int'(idx) == low_set(rem), "R5 idx", 32'(idx), 32'(low_set(rem)));
      chk(we == ~v.load, "R6 we", 32'(we), 32'(~v.load));
      rem[low_set(rem)] = 1'b0;
      n++;
      @(negedge clk);
    end
    chk(done == 1'b1 && req == 1'b0, "R8 done", {30'd0, done, req}, 32'd2);
    chk(wb == v.wb, "R8 wb", wb, v.wb);
    @(negedge clk);
    chk(done == 1'b0, "R8 pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t v;
    string mt;
    repeat (2) @(negedge clk);
    chk(req == 0 && done == 0 && busy == 0 && wb == 0, "R11 reset",
        {req, done, busy, wb[28:0]}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      mt = v.up ? (v.pre ? "R2 addr" : "R1 addr") : (v.pre ? "R4 addr" : "R3 addr");
      kick(v);
      run_checks(v, mt);
    end

    // R9: empty mask
    v = '{32'h0000_3000, 16'h0000, 1'b0, 1'b1, 1'b1, 32'h0, 32'h0000_3000};
    kick(v);
    chk(done == 1'b1 && req == 1'b0, "R9 done", {30'd0, done, req}, 32'd2);
    chk(wb == 32'h0000_3000, "R9 wb", wb, 32'h0000_3000);

    // R7: stall holds beat
    v = '{32'h0000_0100, 16'h0012, 1'b0, 1'b1, 1'b0, 32'h0000_0100, 32'h0000_0108};
    ready = 1'b0;
    kick(v);
    repeat (3) @(negedge clk);
    chk(req == 1'b1 && addr == 32'h100, "R7 hold addr", addr, 32'h100);
    chk(idx == 4'd1, "R7 hold idx", 32'(idx), 32'd1);
    ready = 1'b1;
    @(negedge clk);
    chk(addr == 32'h104 && idx == 4'd4, "R7 advance", addr, 32'h104);
    @(negedge clk);
    chk(done == 1'b1 && wb == 32'h108, "R8 after stall", wb, 32'h108);

    // R10: start during transfer ignored
    v = '{32'h0000_0200, 16'h0007, 1'b0, 1'b1, 1'b1, 32'h0000_0200, 32'h0000_020C};
    kick(v);
    chk(addr == 32'h200, "R10 first", addr, 32'h200);
    base = 32'h0000_9000; list = 16'h0100; up = 1'b0; load = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(addr == 32'h204 && idx == 4'd1, "R10 beat1", addr, 32'h204);
    chk(we == 1'b0, "R10 we", 32'(we), 32'd0);
    @(negedge clk);
    chk(addr == 32'h208 && idx == 4'd2, "R10 beat2", addr, 32'h208);
    @(negedge clk);
    chk(done == 1'b1 && wb == 32'h20C, "R10 wb", wb, 32'h20C);
    @(negedge clk);
    chk(busy == 1'b0 && req == 1'b0, "R10 idle", {30'd0, busy, req}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule